// File: doc/BRIEF.md
# Per-Channel Idle Byte Substitution Unit

This block overwrites selected timeslots of two byte streams, one for the transmit direction and one for the receive direction, with a stored idle byte. Each direction has 32 channel positions. The idle bytes are held in a 64-entry byte array. Entries 0 to 31 belong to transmit channels 1 to 32, and entries 32 to 63 belong to receive channels 1 to 32. A per-channel enable bit decides whether a timeslot is replaced or passed through.

The host reaches the array indirectly. It first writes an index register, whose low six bits select an entry. It then writes the byte into a code register. Two high bits of the index register turn a single code write into a broadcast. The byte then goes to the whole transmit half, the whole receive half, or both halves, and also to the indexed entry. When the T1 input is high, only channels 1 to 24 can be substituted.

On the datapath side each direction takes a valid strobe, a 5-bit channel index (0 means channel 1) and a data byte. It returns a registered byte and a valid flag one cycle later.

Top module: `idle_code_subst`

## Requirements
- R1: After reset all array entries and all enable bits are 0, both output valid flags are 0, and both output bytes are 0.
- R2: A host write to the code register (hostSel 1) stores hostWdata into the array entry named by bits 5:0 of the index register (hostSel 0). Entry c−1 serves transmit channel c, and entry 32+c−1 serves receive channel c.
- R3: When index register bit 6 is 1, a code write stores the byte into entries 0..31 and also into the entry named by bits 5:0. Other receive entries keep their values.
- R4: When index register bit 7 is 1, a code write stores the byte into entries 32..63 and also into the entry named by bits 5:0. Other transmit entries keep their values.
- R5: With both bits 6 and 7 set, one code write fills all 64 entries.
- R6: Enable register n (n = 1..4) controls channels 8(n−1)+1 to 8n, with bit k controlling channel 8(n−1)+k+1. The transmit enable registers are at hostSel 2..5 and the receive enable registers at hostSel 6..9.
- R7: For a valid input byte on channel index i, the output byte one cycle later is entry (direction base + i) if that channel's enable bit is 1, and otherwise the input byte. The output valid flag follows the input valid with one cycle of delay. While no valid byte arrives, the output byte holds its value.
- R8: While t1Mode is 1, channel indices 24..31 (channels 25 to 32) pass through unchanged whatever their enable bits.
- R9: A host read of the code register returns, one cycle later on hostRdata, the entry named by index bits 5:0. This holds even when a broadcast bit is set, and such a read changes no entry. hostRdata holds its value between reads.
- R10: If a code write and a datapath lookup reach the same entry in the same cycle, the lookup returns the entry's previous value.
- R11: The index register and all eight enable registers read back their written values one cycle after a read. Unmapped selects (10..15) read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| t1Mode | input | 1 | Limits substitution to channels 1 to 24 |
| hostWr | input | 1 | Host register write strobe |
| hostRd | input | 1 | Host register read strobe |
| hostSel | input | 4 | Register select: 0 index, 1 code, 2..5 transmit enables, 6..9 receive enables |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Registered host read data |
| txValid | input | 1 | Transmit input byte valid |
| txChan | input | 5 | Transmit channel index (0 = channel 1) |
| txData | input | 8 | Transmit input byte |
| rxValid | input | 1 | Receive input byte valid |
| rxChan | input | 5 | Receive channel index (0 = channel 1) |
| rxData | input | 8 | Receive input byte |
| txOutValid | output | 1 | Transmit output byte valid |
| txOutData | output | 8 | Transmit output byte after substitution |
| rxOutValid | output | 1 | Receive output byte valid |
| rxOutData | output | 8 | Receive output byte after substitution |

## Verification
Every cycle, the assertions check three things: that each lane passes disabled and T1-inactive channels through unchanged, that a substituted byte equals the idle byte presented to the lane, and that output and read data hold while idle. After every code write they also check that the addressed entry and both ends of the broadcast halves took the written byte. Only the bench scenarios can show that broadcast writes leave the opposite half untouched and that a read with a broadcast bit set changes nothing. The same holds for the mapping of enable register bits onto channels and the old-value result when a write and a lookup collide. The bench checks these by comparing against its own model on every clock.

// File: rtl/idle_subst_pkg.sv
package idle_subst_pkg;
  localparam int CHANS     = 32;
  localparam int DIRS      = 2;
  localparam int ENTRIES   = CHANS * DIRS;
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int CH_W      = $clog2(CHANS);
  localparam int BYTE_W    = 8;
  localparam int EN_REGS   = CHANS / BYTE_W;
  localparam int EN_SEL_W  = $clog2(EN_REGS);
  localparam int T1_CHANS  = 24;
  localparam int FILL_TX_BIT = 6;
  localparam int FILL_RX_BIT = 7;

  localparam logic [3:0] SEL_INDEX = 4'd0;
  localparam logic [3:0] SEL_CODE  = 4'd1;
  localparam logic [3:0] SEL_TXEN  = 4'd2;
  localparam logic [3:0] SEL_RXEN  = 4'(2 + EN_REGS);

  typedef struct packed {
    logic                arrWrite;
    logic                fillTx;
    logic                fillRx;
    logic [IDX_W-1:0]    arrIdx;
    logic                enWrite;
    logic                enRx;
    logic [EN_SEL_W-1:0] enByte;
    logic [BYTE_W-1:0]   wData;
  } hostStrobe_t;
endpackage

// File: rtl/idle_subst_ctrl.sv
module idle_subst_ctrl
  import idle_subst_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hostWr,
  input  logic                          hostRd,
  input  logic [3:0]                    hostSel,
  input  logic [BYTE_W-1:0]             hostWdata,
  input  logic [BYTE_W-1:0]             arrRdByte,
  input  logic [DIRS-1:0][CHANS-1:0]    enVec,
  output logic [IDX_W-1:0]              rdIdx,
  output hostStrobe_t                   strobe,
  output logic [BYTE_W-1:0]             hostRdata
);
  logic [BYTE_W-1:0] indexReg;
  logic [BYTE_W-1:0] rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) indexReg <= '0;
    else if (hostWr && hostSel == SEL_INDEX) indexReg <= hostWdata;
  end

  assign rdIdx = indexReg[IDX_W-1:0];

  always_comb begin
    strobe          = '0;
    strobe.wData    = hostWdata;
    strobe.arrIdx   = indexReg[IDX_W-1:0];
    strobe.fillTx   = indexReg[FILL_TX_BIT];
    strobe.fillRx   = indexReg[FILL_RX_BIT];
    strobe.arrWrite = hostWr && (hostSel == SEL_CODE);
    for (int n = 0; n < EN_REGS; n++) begin
      if (hostWr && hostSel == SEL_TXEN + 4'(n)) begin
        strobe.enWrite = 1'b1;
        strobe.enRx    = 1'b0;
        strobe.enByte  = EN_SEL_W'(n);
      end
      if (hostWr && hostSel == SEL_RXEN + 4'(n)) begin
        strobe.enWrite = 1'b1;
        strobe.enRx    = 1'b1;
        strobe.enByte  = EN_SEL_W'(n);
      end
    end
  end

  always_comb begin
    rdMux = '0;
    if (hostSel == SEL_INDEX) rdMux = indexReg;
    if (hostSel == SEL_CODE)  rdMux = arrRdByte;
    for (int n = 0; n < EN_REGS; n++) begin
      if (hostSel == SEL_TXEN + 4'(n)) rdMux = enVec[0][n*BYTE_W +: BYTE_W];
      if (hostSel == SEL_RXEN + 4'(n)) rdMux = enVec[1][n*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostRdata <= '0;
    else if (hostRd) hostRdata <= rdMux;
  end

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd |=> $stable(hostRdata));
endmodule

// File: rtl/idle_subst_lane.sv
module idle_subst_lane
  import idle_subst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              t1Mode,
  input  logic              inValid,
  input  logic [CH_W-1:0]   inChan,
  input  logic [BYTE_W-1:0] inData,
  input  logic [BYTE_W-1:0] idleByte,
  input  logic              enBit,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData
);
  logic chanActive;
  logic doSub;

  assign chanActive = !t1Mode || (int'(inChan) < T1_CHANS);
  assign doSub      = enBit && chanActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) outData <= doSub ? idleByte : inData;
    end
  end

  assert_disabled_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !enBit) |=> (outData == $past(inData)));

  assert_enabled_sub_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && enBit && !t1Mode) |=> (outData == $past(idleByte)));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outData));

  assert_t1_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && t1Mode && int'(inChan) >= T1_CHANS) |=> (outData == $past(inData)));
endmodule

// File: rtl/idle_subst_dp.sv
module idle_subst_dp
  import idle_subst_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          t1Mode,
  input  hostStrobe_t                   strobe,
  input  logic [IDX_W-1:0]              rdIdx,
  input  logic [DIRS-1:0]               inValid,
  input  logic [DIRS-1:0][CH_W-1:0]     inChan,
  input  logic [DIRS-1:0][BYTE_W-1:0]   inData,
  output logic [BYTE_W-1:0]             arrRdByte,
  output logic [DIRS-1:0][CHANS-1:0]    enVec,
  output logic [DIRS-1:0]               outValid,
  output logic [DIRS-1:0][BYTE_W-1:0]   outData
);
  logic [BYTE_W-1:0] idleMem [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam bit IN_RX = (e >= CHANS);
    logic hit;
    assign hit = strobe.arrWrite &&
                 ((strobe.arrIdx == IDX_W'(e)) ||
                  (strobe.fillTx && !IN_RX) ||
                  (strobe.fillRx && IN_RX));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) idleMem[e] <= '0;
      else if (hit) idleMem[e] <= strobe.wData;
    end
  end

  for (genvar d = 0; d < DIRS; d++) begin : g_en_dir
    for (genvar n = 0; n < EN_REGS; n++) begin : g_en_byte
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) enVec[d][n*BYTE_W +: BYTE_W] <= '0;
        else if (strobe.enWrite && (strobe.enRx == d[0]) &&
                 (strobe.enByte == EN_SEL_W'(n)))
          enVec[d][n*BYTE_W +: BYTE_W] <= strobe.wData;
      end
    end
  end

  assign arrRdByte = idleMem[rdIdx];

  for (genvar d = 0; d < DIRS; d++) begin : g_lane
    logic [IDX_W-1:0]  lookIdx;
    logic [BYTE_W-1:0] lookByte;
    assign lookIdx  = IDX_W'(d * CHANS) + IDX_W'(inChan[d]);
    assign lookByte = idleMem[lookIdx];
    idle_subst_lane u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .t1Mode   (t1Mode),
      .inValid  (inValid[d]),
      .inChan   (inChan[d]),
      .inData   (inData[d]),
      .idleByte (lookByte),
      .enBit    (enVec[d][inChan[d]]),
      .outValid (outValid[d]),
      .outData  (outData[d])
    );
  end

  assert_entry_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && strobe.arrWrite) |-> (idleMem[$past(strobe.arrIdx)] == $past(strobe.wData)));

  assert_fill_tx_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && strobe.arrWrite && strobe.fillTx) |->
      (idleMem[0] == $past(strobe.wData) && idleMem[CHANS-1] == $past(strobe.wData)));

  assert_fill_rx_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && strobe.arrWrite && strobe.fillRx) |->
      (idleMem[CHANS] == $past(strobe.wData) && idleMem[ENTRIES-1] == $past(strobe.wData)));
endmodule

// File: rtl/idle_code_subst.sv
module idle_code_subst
  import idle_subst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              t1Mode,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [3:0]        hostSel,
  input  logic [BYTE_W-1:0] hostWdata,
  output logic [BYTE_W-1:0] hostRdata,
  input  logic              txValid,
  input  logic [CH_W-1:0]   txChan,
  input  logic [BYTE_W-1:0] txData,
  input  logic              rxValid,
  input  logic [CH_W-1:0]   rxChan,
  input  logic [BYTE_W-1:0] rxData,
  output logic              txOutValid,
  output logic [BYTE_W-1:0] txOutData,
  output logic              rxOutValid,
  output logic [BYTE_W-1:0] rxOutData
);
  hostStrobe_t                  strobe;
  logic [IDX_W-1:0]             rdIdx;
  logic [BYTE_W-1:0]            arrRdByte;
  logic [DIRS-1:0][CHANS-1:0]   enVec;
  logic [DIRS-1:0]              outValid;
  logic [DIRS-1:0][BYTE_W-1:0]  outData;

  idle_subst_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostSel   (hostSel),
    .hostWdata (hostWdata),
    .arrRdByte (arrRdByte),
    .enVec     (enVec),
    .rdIdx     (rdIdx),
    .strobe    (strobe),
    .hostRdata (hostRdata)
  );

  idle_subst_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .t1Mode    (t1Mode),
    .strobe    (strobe),
    .rdIdx     (rdIdx),
    .inValid   ({rxValid, txValid}),
    .inChan    ({rxChan, txChan}),
    .inData    ({rxData, txData}),
    .arrRdByte (arrRdByte),
    .enVec     (enVec),
    .outValid  (outValid),
    .outData   (outData)
  );

  assign txOutValid = outValid[0];
  assign txOutData  = outData[0];
  assign rxOutValid = outValid[1];
  assign rxOutData  = outData[1];
endmodule

// File: tb/idle_code_subst_bench.sv
module idle_code_subst_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       t1Mode = 1'b0;
  logic       hostWr = 1'b0, hostRd = 1'b0;
  logic [3:0] hostSel = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       txValid = 1'b0, rxValid = 1'b0;
  logic [4:0] txChan = '0, rxChan = '0;
  logic [7:0] txData = '0, rxData = '0;
  logic       txOutValid, rxOutValid;
  logic [7:0] txOutData, rxOutData;

  always #10 clk = ~clk;

  idle_code_subst u_idle_code_subst (
    .clk(clk), .rstN(rstN), .t1Mode(t1Mode),
    .hostWr(hostWr), .hostRd(hostRd), .hostSel(hostSel),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .txValid(txValid), .txChan(txChan), .txData(txData),
    .rxValid(rxValid), .rxChan(rxChan), .rxData(rxData),
    .txOutValid(txOutValid), .txOutData(txOutData),
    .rxOutValid(rxOutValid), .rxOutData(rxOutData)
  );

  int testsRun = 0, testsFailed = 0, cycles = 0;
  string curReq = "R1";

  int mem [64];
  bit [31:0] txEnM, rxEnM;
  int idxM;
  int expTxD, expRxD, expRd;
  bit expTxV, expRxV, expRdV;

  task automatic check(string req, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int substM(int dir, int ch, int d);
    bit en = dir ? rxEnM[ch] : txEnM[ch];
    if (en && (!t1Mode || ch < 24)) return mem[dir*32 + ch];
    return d;
  endfunction

  function automatic int readM(int sel);
    if (sel == 0) return idxM;
    if (sel == 1) return mem[idxM % 64];
    if (sel >= 2 && sel <= 5) return int'(txEnM[(sel-2)*8 +: 8]);
    if (sel >= 6 && sel <= 9) return int'(rxEnM[(sel-6)*8 +: 8]);
    return 0;
  endfunction

  task automatic tick();
    expTxV = txValid;
    expRxV = rxValid;
    if (txValid) expTxD = substM(0, int'(txChan), int'(txData));
    if (rxValid) expRxD = substM(1, int'(rxChan), int'(rxData));
    expRdV = hostRd;
    if (hostRd) expRd = readM(int'(hostSel));
    if (hostWr) begin
      int s = int'(hostSel);
      if (s == 0) idxM = int'(hostWdata);
      else if (s == 1) begin
        for (int i = 0; i < 64; i++)
          if (i == idxM % 64 || (idxM[6] && i < 32) || (idxM[7] && i >= 32))
            mem[i] = int'(hostWdata);
      end
      else if (s >= 2 && s <= 5) txEnM[(s-2)*8 +: 8] = hostWdata;
      else if (s >= 6 && s <= 9) rxEnM[(s-6)*8 +: 8] = hostWdata;
    end
    @(negedge clk);
    check(curReq, "txOutValid", int'(txOutValid), int'(expTxV));
    check(curReq, "rxOutValid", int'(rxOutValid), int'(expRxV));
    if (expTxV) check(curReq, "txOutData", int'(txOutData), expTxD);
    if (expRxV) check(curReq, "rxOutData", int'(rxOutData), expRxD);
    if (expRdV) check(curReq, "hostRdata", int'(hostRdata), expRd);
  endtask

  task automatic hostWrite(int sel, int val);
    hostWr = 1'b1; hostSel = 4'(sel); hostWdata = 8'(val);
    tick();
    hostWr = 1'b0;
  endtask

  task automatic hostRead(int sel);
    hostRd = 1'b1; hostSel = 4'(sel);
    tick();
    hostRd = 1'b0;
  endtask

  task automatic readEntry(int idx);
    hostWrite(0, idx);
    hostRead(1);
  endtask

  task automatic streamBoth(int seed);
    for (int c = 0; c < 32; c++) begin
      txValid = 1'b1; txChan = 5'(c); txData = 8'(seed + c);
      rxValid = 1'b1; rxChan = 5'(31 - c); rxData = 8'(seed + 3*c);
      tick();
    end
    txValid = 1'b0; rxValid = 1'b0;
    tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    txEnM = '0; rxEnM = '0; idxM = 0;
    expTxD = 0; expRxD = 0; expRd = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    curReq = "R1";
    check("R1", "txOutValid reset", int'(txOutValid), 0);
    check("R1", "txOutData reset", int'(txOutData), 0);
    check("R1", "rxOutData reset", int'(rxOutData), 0);
    readEntry(0); readEntry(45); readEntry(63);
    for (int s = 2; s <= 9; s++) hostRead(s);

    curReq = "R2";
    hostWrite(0, 5);  hostWrite(1, 8'hA5);
    hostWrite(0, 37); hostWrite(1, 8'h3C);
    readEntry(5); readEntry(37); readEntry(6);

    curReq = "R11";
    hostWrite(0, 8'h25); hostRead(0);
    hostWrite(12, 8'h55); hostRead(12);
    hostWrite(4, 8'h81); hostRead(4); hostWrite(4, 0); hostRead(4);

    curReq = "R6";
    hostWrite(2, 8'h20);
    hostWrite(6, 8'h20);
    hostWrite(9, 8'h80);
    hostRead(2); hostRead(6); hostRead(9);

    curReq = "R7";
    streamBoth(8'h40);
    txValid = 1'b1; txChan = 5'd5; txData = 8'h01; tick();
    txValid = 1'b0; tick(); tick();

    curReq = "R3";
    hostWrite(0, 8'h40 | 40); hostWrite(1, 8'h11);
    hostWrite(0, 40); hostRead(1);
    readEntry(0); readEntry(31); readEntry(37); readEntry(32);
    hostWrite(3, 8'hFF);
    streamBoth(8'h10);

    curReq = "R4";
    hostWrite(0, 8'h80 | 3); hostWrite(1, 8'h22);
    readEntry(3); readEntry(4); readEntry(32); readEntry(63);
    streamBoth(8'h90);

    curReq = "R5";
    hostWrite(0, 8'hC0 | 17); hostWrite(1, 8'h7E);
    readEntry(0); readEntry(17); readEntry(40); readEntry(63);

    curReq = "R9";
    hostWrite(0, 10); hostWrite(1, 8'h5A);
    hostWrite(0, 8'h40 | 10); hostRead(1);
    hostWrite(0, 8'h80 | 10); hostRead(1);
    readEntry(10); readEntry(11); readEntry(50);
    tick(); tick();

    curReq = "R8";
    hostWrite(2, 8'hFF); hostWrite(3, 8'hFF); hostWrite(4, 8'hFF); hostWrite(5, 8'hFF);
    hostWrite(6, 8'hFF); hostWrite(7, 8'hFF); hostWrite(8, 8'hFF); hostWrite(9, 8'hFF);
    t1Mode = 1'b1;
    streamBoth(8'h00);
    t1Mode = 1'b0;
    streamBoth(8'h33);

    curReq = "R10";
    hostWrite(0, 2);
    hostWr = 1'b1; hostSel = 4'd1; hostWdata = 8'h99;
    txValid = 1'b1; txChan = 5'd2; txData = 8'h02;
    tick();
    hostWr = 1'b0;
    tick();
    txValid = 1'b0; tick();
    check("R10", "entry 2 after collision", mem[2], 8'h99);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule